// File: doc/BRIEF.md
# OTP Row Programming Sequencer

This block runs one manual write of a 64-bit word into a row of one-time-programmable storage. Software holds the two 32-bit halves of the word, a 13-bit row address and an 8-bit pulse-width count on the inputs. It then raises a one-cycle start strobe. The sequencer walks the set bits of the word from bit 0 upward. For each set bit it applies a programming pulse that is held for (count + 1) cycles, then spends one cycle reading that bit back. Any bit that still reads 0 goes into a failure mask.

When the walk ends, the block classifies the outcome as clean, correctable (exactly one bad bit) or uncorrectable (two or more bad bits). A word of all zeros is not pulsed at all and is reported as skipped. A retry request pulses only the bits held in the failure mask of the previous attempt, so bits that already took their value are not stressed again. The storage is a behavioural array. A stuck-bit mask input marks cells that refuse to take a 1, which lets failures be injected. A read port shows the contents of any row.

Top module: `otp_row_prog`

## Requirements
- R1: After reset `ready_o` is 1 and all three outcome flags are 0. `ready_o` is 0 for every cycle of an operation. A start that arrives while `ready_o` is 0 is ignored.
- R2: A first attempt (`retry_i` = 0) pulses exactly the bits that are 1 in {`wdata_hi_i`,`wdata_lo_i`} (bit 0 of the word is bit 0 of `wdata_lo_i`), in ascending order. `pgm_bit_o` gives the bit index while `pgm_strobe_o` is 1. Each pulse is followed by one verify cycle, so an operation over n bits keeps `ready_o` low for n*(W+2) cycles.
- R3: The pulse width W is taken from `pulse_w_i` when the start is accepted. Each bit keeps `pgm_strobe_o` high for W+1 consecutive cycles, and W = 0 gives one-cycle pulses.
- R4: When the set of bits to pulse is empty, no pulse is applied and `ready_o` stays 1. `zero_skip_o` is set exactly when the data word is all zeros.
- R5: If exactly one pulsed bit still reads 0 at its verify cycle, the operation ends with `corr_fail_o` = 1 and `uncorr_fail_o` = 0.
- R6: If two or more pulsed bits fail, the operation ends with `uncorr_fail_o` = 1 and `corr_fail_o` = 0.
- R7: A retry (`retry_i` = 1 with start) pulses only the bits recorded as failed by the previous operation. If they now program, all flags end at 0.
- R8: A retry requested when no start has been accepted since reset is ignored. No pulse is applied, `ready_o` stays 1, and the flags and array contents are unchanged.
- R9: All three outcome flags read 0 in the cycle after a start is accepted.
- R10: The row is selected by the low log2(ROWS) bits of `row_addr_i`. A bit whose `stuck_i` bit is 1 during its pulse is not set. `rd_data_o` shows the row selected by `rd_row_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| retry_i | input | 1 | 0: first attempt, 1: retry of failed bits |
| wdata_lo_i | input | 32 | Bits 31:0 of the word to program |
| wdata_hi_i | input | 32 | Bits 63:32 of the word to program |
| row_addr_i | input | 13 | Target row address |
| pulse_w_i | input | 8 | Pulse width count W, pulse lasts W+1 cycles |
| stuck_i | input | 64 | Injection mask: bits set here refuse to program |
| rd_row_i | input | 13 | Row address for the read port |
| rd_data_o | output | 64 | Contents of the row selected by rd_row_i |
| ready_o | output | 1 | 1 when idle, 0 while an operation runs |
| pgm_strobe_o | output | 1 | Programming pulse active |
| pgm_bit_o | output | 6 | Bit index under the current pulse |
| zero_skip_o | output | 1 | Last operation skipped an all-zero word |
| corr_fail_o | output | 1 | Last operation left exactly one bit failed |
| uncorr_fail_o | output | 1 | Last operation left two or more bits failed |

## Verification
Two events can meet in one cycle: a new start request and the verify cycle of the last bit, which returns the block to idle. The bench raises start during that final verify cycle, carrying a different data word for the same row. It then checks that `ready_o` is 1 and stays 1 with no pulse, and that the row shows only the bits of the first word. A second pairing is a flag result landing in the cycle a fresh start is accepted. This is judged by the per-cycle reference model, which clears the flags only on an accepted start.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;
    localparam int WORD_W = 64;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int ADDR_W = 13;
    localparam int CNT_W  = 8;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_PULSE  = 2'd1,
        PH_VERIFY = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [WORD_W-1:0]   todo;
        logic [WORD_W-1:0]   fail;
        logic [IDX_W-1:0]    cur;
        logic [CNT_W-1:0]    cnt;
        logic [CNT_W-1:0]    width;
        logic [ADDR_W-1:0]   row;
        logic                attempted;
        logic                zero_skip;
        logic                corr;
        logic                uncorr;
    } seq_state_t;
endpackage

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int ROWS   = 16,
    parameter int W      = 64,
    parameter int ADDR_W = 13,
    localparam int ROW_W = $clog2(ROWS),
    localparam int IW    = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_row_i,
    input  logic [IW-1:0]     wr_bit_i,
    input  logic [W-1:0]      stuck_i,
    output logic              vf_val_o,
    input  logic [ADDR_W-1:0] rd_row_i,
    output logic [W-1:0]      rd_data_o
);
    logic [W-1:0] mem_q [ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
        end else if (wr_en_i && !stuck_i[wr_bit_i]) begin
            mem_q[wr_row_i[ROW_W-1:0]][wr_bit_i] <= 1'b1;
        end
    end

    assign vf_val_o  = mem_q[wr_row_i[ROW_W-1:0]][wr_bit_i];
    assign rd_data_o = mem_q[rd_row_i[ROW_W-1:0]];
endmodule

// File: rtl/otp_lowest_bit.sv
module otp_lowest_bit #(
    parameter int W = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/otp_fail_class.sv
module otp_fail_class #(
    parameter int W = 64,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0] fail_i,
    output logic         single_o,
    output logic         multi_o
);
    logic [CW-1:0] n_fail;

    always_comb begin
        n_fail   = CW'($countones(fail_i));
        single_o = (n_fail == CW'(1));
        multi_o  = (n_fail > CW'(1));
    end
endmodule

// File: rtl/otp_row_prog.sv
module otp_row_prog
    import otp_prog_pkg::*;
#(
    parameter int ROWS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              retry_i,
    input  logic [31:0]       wdata_lo_i,
    input  logic [31:0]       wdata_hi_i,
    input  logic [ADDR_W-1:0] row_addr_i,
    input  logic [CNT_W-1:0]  pulse_w_i,
    input  logic [WORD_W-1:0] stuck_i,
    input  logic [ADDR_W-1:0] rd_row_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              ready_o,
    output logic              pgm_strobe_o,
    output logic [IDX_W-1:0]  pgm_bit_o,
    output logic              zero_skip_o,
    output logic              corr_fail_o,
    output logic              uncorr_fail_o
);
    seq_state_t s_d, s_q;

    logic [WORD_W-1:0] word_in;
    logic [WORD_W-1:0] target;
    logic [WORD_W-1:0] todo_rest;
    logic [WORD_W-1:0] fail_upd;
    logic [WORD_W-1:0] pick_vec;
    logic [IDX_W-1:0]  pick_idx;
    logic              vf_val;
    logic              cls_single, cls_multi;
    logic              accept;

    assign word_in   = {wdata_hi_i, wdata_lo_i};
    assign target    = retry_i ? s_q.fail : word_in;
    assign todo_rest = s_q.todo & ~(WORD_W'(1) << s_q.cur);
    assign fail_upd  = vf_val ? s_q.fail : (s_q.fail | (WORD_W'(1) << s_q.cur));
    assign pick_vec  = (s_q.phase == PH_IDLE) ? target : todo_rest;
    assign accept    = (s_q.phase == PH_IDLE) && start_i && !(retry_i && !s_q.attempted);

    otp_lowest_bit #(.W(WORD_W)) u_pick (
        .vec_i (pick_vec),
        .idx_o (pick_idx)
    );

    otp_fail_class #(.W(WORD_W)) u_class (
        .fail_i   (fail_upd),
        .single_o (cls_single),
        .multi_o  (cls_multi)
    );

    otp_cell_array #(.ROWS(ROWS), .W(WORD_W), .ADDR_W(ADDR_W)) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (s_q.phase == PH_PULSE),
        .wr_row_i  (s_q.row),
        .wr_bit_i  (s_q.cur),
        .stuck_i   (stuck_i),
        .vf_val_o  (vf_val),
        .rd_row_i  (rd_row_i),
        .rd_data_o (rd_data_o)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    s_d.attempted = 1'b1;
                    s_d.zero_skip = 1'b0;
                    s_d.corr      = 1'b0;
                    s_d.uncorr    = 1'b0;
                    s_d.row       = row_addr_i;
                    s_d.width     = pulse_w_i;
                    s_d.fail      = '0;
                    if (target == '0) begin
                        s_d.zero_skip = (word_in == '0);
                    end else begin
                        s_d.todo  = target;
                        s_d.cur   = pick_idx;
                        s_d.cnt   = pulse_w_i;
                        s_d.phase = PH_PULSE;
                    end
                end
            end
            PH_PULSE: begin
                if (s_q.cnt == '0) s_d.phase = PH_VERIFY;
                else               s_d.cnt   = s_q.cnt - CNT_W'(1);
            end
            PH_VERIFY: begin
                s_d.fail = fail_upd;
                s_d.todo = todo_rest;
                if (todo_rest == '0) begin
                    s_d.phase  = PH_IDLE;
                    s_d.corr   = cls_single;
                    s_d.uncorr = cls_multi;
                end else begin
                    s_d.cur   = pick_idx;
                    s_d.cnt   = s_q.width;
                    s_d.phase = PH_PULSE;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ready_o       = (s_q.phase == PH_IDLE);
    assign pgm_strobe_o  = (s_q.phase == PH_PULSE);
    assign pgm_bit_o     = s_q.cur;
    assign zero_skip_o   = s_q.zero_skip;
    assign corr_fail_o   = s_q.corr;
    assign uncorr_fail_o = s_q.uncorr;
endmodule

// File: rtl/otp_row_prog_chk.sv
module otp_row_prog_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        retry_i,
    input logic [31:0] wdata_lo_i,
    input logic [31:0] wdata_hi_i,
    input logic        ready_o,
    input logic        pgm_strobe_o,
    input logic [5:0]  pgm_bit_o,
    input logic        zero_skip_o,
    input logic        corr_fail_o,
    input logic        uncorr_fail_o
);
    // R1: a pulse never coincides with idle
    p_busy_during_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_strobe_o |-> !ready_o);

    // R2: the pulsed bit index holds for the whole pulse
    p_bit_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_strobe_o |=> (!pgm_strobe_o || $stable(pgm_bit_o)));

    // R2: each pulse is followed by a busy verify cycle
    p_verify_after_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pgm_strobe_o) |-> !ready_o);

    // R5/R6: outcome flags are mutually exclusive
    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({zero_skip_o, corr_fail_o, uncorr_fail_o}));

    // R4: zero word first attempt skips and stays idle
    p_zero_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i && !retry_i && {wdata_hi_i, wdata_lo_i} == 64'd0)
        |=> (ready_o && !pgm_strobe_o && zero_skip_o));

    // R9: accepted first attempt clears failure flags
    p_clear_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i && !retry_i) |=> (!corr_fail_o && !uncorr_fail_o));
endmodule

bind otp_row_prog otp_row_prog_chk u_chk (.*);

// File: tb/otp_row_prog_tb.sv
module otp_row_prog_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, retry_i = 1'b0;
    logic [31:0] wdata_lo_i = '0, wdata_hi_i = '0;
    logic [12:0] row_addr_i = '0, rd_row_i = '0;
    logic [7:0]  pulse_w_i = '0;
    logic [63:0] stuck_i = '0;
    logic [63:0] rd_data_o;
    logic        ready_o, pgm_strobe_o, zero_skip_o, corr_fail_o, uncorr_fail_o;
    logic [5:0]  pgm_bit_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    otp_row_prog u_dut (.*);

    // behavioural reference model
    logic [63:0] m_cell [16];
    int          m_q[$];
    int          m_ph, m_cur, m_cnt, m_w, m_row;
    logic [63:0] m_fail;
    bit          m_att, m_zs, m_cor, m_unc;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cell[r]) m_cell[r] = '0;
            m_q.delete(); m_ph = 0; m_cur = 0; m_cnt = 0; m_w = 0; m_row = 0;
            m_fail = '0; m_att = 0; m_zs = 0; m_cor = 0; m_unc = 0;
        end else if (m_ph == 0) begin
            if (start_i && !(retry_i && !m_att)) begin
                logic [63:0] tg;
                tg = retry_i ? m_fail : {wdata_hi_i, wdata_lo_i};
                m_att = 1; m_zs = 0; m_cor = 0; m_unc = 0; m_fail = '0;
                m_row = int'(row_addr_i[3:0]); m_w = int'(pulse_w_i);
                m_q.delete();
                for (int b = 0; b < 64; b++) if (tg[b]) m_q.push_back(b);
                if (m_q.size() == 0) m_zs = ({wdata_hi_i, wdata_lo_i} == 64'd0);
                else begin m_cur = m_q.pop_front(); m_cnt = m_w; m_ph = 1; end
            end
        end else if (m_ph == 1) begin
            if (!stuck_i[m_cur]) m_cell[m_row][m_cur] = 1'b1;
            if (m_cnt == 0) m_ph = 2; else m_cnt--;
        end else begin
            if (!m_cell[m_row][m_cur]) m_fail[m_cur] = 1'b1;
            if (m_q.size() == 0) begin
                m_ph = 0;
                m_cor = ($countones(m_fail) == 1);
                m_unc = ($countones(m_fail) > 1);
            end else begin
                m_cur = m_q.pop_front(); m_cnt = m_w; m_ph = 1;
            end
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 ready", 64'(ready_o), 64'(m_ph == 0));
            chk("R3 strobe", 64'(pgm_strobe_o), 64'(m_ph == 1));
            if (m_ph == 1) chk("R2 bit index", 64'(pgm_bit_o), 64'(m_cur));
            chk("R4 zero_skip", 64'(zero_skip_o), 64'(m_zs));
            chk("R5 corr", 64'(corr_fail_o), 64'(m_cor));
            chk("R6 uncorr", 64'(uncorr_fail_o), 64'(m_unc));
            chk("R10 read port", rd_data_o, m_cell[rd_row_i[3:0]]);
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    // one full operation; returns busy and strobe cycle counts
    task automatic run(input logic [31:0] lo, hi, input logic [12:0] adr,
                       input logic [7:0] w, input logic rt, input logic [63:0] stk,
                       output int busy, output int strobes);
        wdata_lo_i = lo; wdata_hi_i = hi; row_addr_i = adr; pulse_w_i = w;
        retry_i = rt; stuck_i = stk; start_i = 1'b1;
        step();
        start_i = 1'b0;
        busy = 0; strobes = 0;
        if (!ready_o) chk("R9 flags cleared on accept",
                          64'({corr_fail_o, uncorr_fail_o, zero_skip_o}), 64'd0);
        while (!ready_o && busy < 5000) begin
            busy++;
            if (pgm_strobe_o) strobes++;
            step();
        end
    endtask

    initial begin
        int bz, st;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 reset ready", 64'(ready_o), 64'd1);
        chk("R1 reset flags", 64'({zero_skip_o, corr_fail_o, uncorr_fail_o}), 64'd0);

        // R8: retry before any attempt is ignored
        run(32'hFFFF_FFFF, 32'h0, 13'd0, 8'd1, 1'b1, 64'd0, bz, st);
        chk("R8 retry ignored busy", 64'(bz), 64'd0);
        step();
        chk("R8 retry no pulse", 64'(pgm_strobe_o), 64'd0);
        rd_row_i = 13'd0; #1;
        chk("R8 array untouched", rd_data_o, 64'd0);

        // R4: zero word skipped
        run(32'h0, 32'h0, 13'd1, 8'd3, 1'b0, 64'd0, bz, st);
        chk("R4 zero busy", 64'(bz), 64'd0);
        chk("R4 zero flag", 64'(zero_skip_o), 64'd1);

        // R2/R3/R10: four bits, W=2, row alias 0x1002 -> row 2
        run(32'h0000_0013, 32'h8000_0000, 13'h1002, 8'd2, 1'b0, 64'd0, bz, st);
        chk("R2 busy cycles", 64'(bz), 64'd16);
        chk("R3 strobe cycles", 64'(st), 64'd12);
        chk("R2 clean flags", 64'({zero_skip_o, corr_fail_o, uncorr_fail_o}), 64'd0);
        rd_row_i = 13'd2; #1;
        chk("R10 row 2 data", rd_data_o, 64'h8000_0000_0000_0013);
        rd_row_i = 13'd0; #1;
        chk("R10 row 0 untouched", rd_data_o, 64'd0);

        // R5: one stuck bit, W=0
        run(32'h0000_00FF, 32'h0, 13'd3, 8'd0, 1'b0, 64'h20, bz, st);
        chk("R5 corr flag", 64'(corr_fail_o), 64'd1);
        chk("R3 W=0 strobes", 64'(st), 64'd8);
        rd_row_i = 13'd3; #1;
        chk("R10 stuck bit clear", rd_data_o, 64'h0000_0000_0000_00DF);

        // R6: two stuck bits
        run(32'h0000_F0F0, 32'h1, 13'd4, 8'd1, 1'b0, 64'h0000_0001_0000_0010, bz, st);
        chk("R6 uncorr flag", 64'(uncorr_fail_o), 64'd1);
        chk("R6 corr low", 64'(corr_fail_o), 64'd0);

        // R7: retry re-pulses only the two failed bits
        run(32'h0000_F0F0, 32'h1, 13'd4, 8'd1, 1'b1, 64'd0, bz, st);
        chk("R7 retry strobes", 64'(st), 64'd4);
        chk("R7 retry busy", 64'(bz), 64'd6);
        chk("R7 flags clear", 64'({zero_skip_o, corr_fail_o, uncorr_fail_o}), 64'd0);
        rd_row_i = 13'd4; #1;
        chk("R7 row complete", rd_data_o, 64'h0000_0001_0000_F0F0);

        // R9: fresh start after a correctable result
        run(32'h1, 32'h0, 13'd5, 8'd0, 1'b0, 64'h1, bz, st);
        chk("R9 corr before", 64'(corr_fail_o), 64'd1);
        run(32'h2, 32'h0, 13'd5, 8'd0, 1'b0, 64'h0, bz, st);
        chk("R9 corr after", 64'(corr_fail_o), 64'd0);

        // R1: start during the final verify cycle is ignored
        wdata_lo_i = 32'h1; wdata_hi_i = '0; row_addr_i = 13'd6; pulse_w_i = 8'd0;
        retry_i = 1'b0; stuck_i = '0; start_i = 1'b1;
        step();
        start_i = 1'b0;
        chk("R1 pulse cycle busy", 64'(ready_o), 64'd0);
        step();
        chk("R1 verify cycle busy", 64'(pgm_strobe_o), 64'd0);
        wdata_lo_i = 32'h6; start_i = 1'b1;
        step();
        start_i = 1'b0;
        chk("R1 idle after verify", 64'(ready_o), 64'd1);
        step();
        chk("R1 late start ignored", 64'(ready_o), 64'd1);
        rd_row_i = 13'd6; #1;
        chk("R1 row keeps first word", rd_data_o, 64'd1);

        repeat (2) step();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule